// File: doc/BRIEF.md
# Write Barrier Bridge for Select-Toggling Peripherals

This bridge connects a single request/acknowledge bus master to an external static-memory bus. Some peripherals on that bus only latch a write when their select line toggles between accesses. The memory controller, however, keeps the select asserted across back-to-back accesses to the same region. The bridge fixes this without software help. Whenever the master writes inside a programmable protected window, the bridge follows that write with one dummy read to a separate barrier address. That read moves the external bus to another decoded region, which releases the peripheral's select line.

The write and its barrier read form one sequence that cannot be split. The bridge does not accept another master request until both external transactions have completed. The master's acknowledge arrives only after the barrier read finishes. The data returned by the barrier read is discarded. Reads inside the window, and every access outside it, pass through unchanged as single transactions.

The barrier target is programmable, but it is honoured only when it lies in the decoded region fixed by parameters and outside the protected window. Otherwise the bridge falls back to the base of the decoded region. A saturating counter reports how many barrier reads have completed.

Top module: `wr_barrier_bridge`

## Requirements
- R1: While reset is low and just after it is released, `m_ack` and `x_req` are 0 and `bar_count` is 0.
- R2: A master read at any address, and a master write with an address outside the window, produce exactly one external transaction. That transaction carries the master's address, write-enable and write data. A read returns the external read data on `m_rdata` with the acknowledge.
- R3: A master write whose address satisfies `cfg_win_lo <= m_addr <= cfg_win_hi` (both bounds inclusive) produces exactly two external transactions, in this order: first the write as issued, then a read (`x_we` = 0) from the barrier address. No other external transaction comes between them.
- R4: `m_ack` for a protected write is raised only after the barrier read has been acknowledged on the memory side. For every access, `m_ack` is high for exactly one cycle.
- R5: Any write acknowledge returns `m_rdata` = 0. The data from the barrier read never reaches `m_rdata`.
- R6: The barrier address is `cfg_bar_addr` when that value lies within the decoded region `[DEC_LO, DEC_HI]` and outside the protected window. Otherwise it is `DEC_LO`.
- R7: `bar_count` rises by one for each completed barrier read and holds at its all-ones maximum instead of wrapping.
- R8: Once `x_req` is raised, it stays high with `x_addr`, `x_we` and `x_wdata` unchanged until the cycle in which `x_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 1 | Master request, held until `m_ack` |
| m_we | input | 1 | Master write enable (1 = write) |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_ack | output | 1 | One-cycle acknowledge to the master |
| m_rdata | output | DATA_W | Read data, valid with `m_ack` |
| x_req | output | 1 | External bus request |
| x_we | output | 1 | External write enable |
| x_addr | output | ADDR_W | External address |
| x_wdata | output | DATA_W | External write data |
| x_ack | input | 1 | External one-cycle acknowledge |
| x_rdata | input | DATA_W | External read data, valid with `x_ack` |
| cfg_win_lo | input | ADDR_W | Lowest address of the protected window |
| cfg_win_hi | input | ADDR_W | Highest address of the protected window |
| cfg_bar_addr | input | ADDR_W | Requested barrier read address |
| bar_count | output | CNT_W | Saturating count of completed barrier reads |

## Verification
The properties assume the master keeps `m_req`, `m_we`, `m_addr` and `m_wdata` steady from request to acknowledge. They also assume `x_ack` only pulses for one cycle while `x_req` is high, and that the window bounds and barrier address stay unchanged while a transfer is in flight. The bench master drives and releases requests only on falling edges, and only after it has seen the acknowledge. Its memory responder raises a single-cycle acknowledge after a programmable wait. Configuration is changed only while the bridge is idle. The bench varies the wait from zero to three cycles, so the hold and ordering rules are exercised both with immediate and with delayed memory responses.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

   // Sequencer states of the write barrier bridge
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // waiting for a master request
      ST_FWD  = 2'd1,   // master access driven on the external bus
      ST_BAR  = 2'd2,   // barrier read driven on the external bus
      ST_RESP = 2'd3    // acknowledge pulse back to the master
   } wbb_state_e;

endpackage

// File: rtl/wbb_win_dec.sv
module wbb_win_dec #(
   parameter int unsigned AW          = 16,
   parameter bit          HI_INCLUSIVE = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic          hit
);

   logic above_lo;
   logic below_hi;

   assign above_lo = (addr >= lo);

   generate
      if (HI_INCLUSIVE) begin : g_incl
         assign below_hi = (addr <= hi);
      end else begin : g_excl
         assign below_hi = (addr < hi);
      end
   endgenerate

   assign hit = above_lo & below_hi;

endmodule

// File: rtl/wbb_bar_sel.sv
module wbb_bar_sel #(
   parameter int unsigned   AW           = 16,
   parameter bit            HI_INCLUSIVE = 1'b1,
   parameter logic [AW-1:0] DEC_LO       = '0,
   parameter logic [AW-1:0] DEC_HI       = '1
) (
   input  logic [AW-1:0] cfg_bar,
   input  logic [AW-1:0] win_lo,
   input  logic [AW-1:0] win_hi,
   output logic [AW-1:0] bar_addr
);

   logic in_decoded;
   logic in_window;
   logic usable;

   assign in_decoded = (cfg_bar >= DEC_LO) && (cfg_bar <= DEC_HI);

   wbb_win_dec #(
      .AW           (AW),
      .HI_INCLUSIVE (HI_INCLUSIVE)
   ) u_bar_win (
      .addr (cfg_bar),
      .lo   (win_lo),
      .hi   (win_hi),
      .hit  (in_window)
   );

   assign usable   = in_decoded & ~in_window;
   assign bar_addr = usable ? cfg_bar : DEC_LO;

endmodule

// File: rtl/wbb_bar_cnt.sv
module wbb_bar_cnt #(
   parameter int unsigned CW       = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
   localparam logic [CW-1:0] FULL = '1;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               count <= '0;
            end else if (inc && (count != FULL)) begin
               count <= count + ONE;
            end
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               count <= '0;
            end else if (inc) begin
               count <= count + ONE;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
   import wbb_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   // master side
   input  logic          m_req,
   input  logic          m_we,
   input  logic [AW-1:0] m_addr,
   input  logic [DW-1:0] m_wdata,
   input  logic          m_hit,
   output logic          m_ack,
   output logic [DW-1:0] m_rdata,
   // barrier target chosen for this access
   input  logic [AW-1:0] bar_addr,
   // external side
   output logic          x_req,
   output logic          x_we,
   output logic [AW-1:0] x_addr,
   output logic [DW-1:0] x_wdata,
   input  logic          x_ack,
   input  logic [DW-1:0] x_rdata,
   // completion of a barrier read
   output logic          bar_done
);

   wbb_state_e    st_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] bar_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          we_q;
   logic          prot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         bar_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         we_q    <= 1'b0;
         prot_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (m_req) begin
                  addr_q  <= m_addr;
                  wdata_q <= m_wdata;
                  we_q    <= m_we;
                  prot_q  <= m_we & m_hit;
                  bar_q   <= bar_addr;
                  st_q    <= ST_FWD;
               end
            end
            ST_FWD: begin
               if (x_ack) begin
                  if (prot_q) begin
                     st_q <= ST_BAR;
                  end else begin
                     rdata_q <= we_q ? '0 : x_rdata;
                     st_q    <= ST_RESP;
                  end
               end
            end
            ST_BAR: begin
               if (x_ack) begin
                  rdata_q <= '0;
                  st_q    <= ST_RESP;
               end
            end
            ST_RESP: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      x_req   = (st_q == ST_FWD) || (st_q == ST_BAR);
      x_we    = (st_q == ST_FWD) && we_q;
      x_addr  = (st_q == ST_BAR) ? bar_q : addr_q;
      x_wdata = (st_q == ST_FWD) ? wdata_q : '0;
      m_ack   = (st_q == ST_RESP);
      m_rdata = rdata_q;
   end

   assign bar_done = (st_q == ST_BAR) && x_ack;

endmodule

// File: rtl/wr_barrier_bridge.sv
module wr_barrier_bridge #(
   parameter int unsigned       ADDR_W       = 16,
   parameter int unsigned       DATA_W       = 16,
   parameter int unsigned       CNT_W        = 8,
   parameter bit                CNT_SATURATE = 1'b1,
   parameter bit                HI_INCLUSIVE = 1'b1,
   parameter logic [ADDR_W-1:0] DEC_LO       = 'h8000,
   parameter logic [ADDR_W-1:0] DEC_HI       = 'hBFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_we,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DATA_W-1:0] m_wdata,
   output logic              m_ack,
   output logic [DATA_W-1:0] m_rdata,
   output logic              x_req,
   output logic              x_we,
   output logic [ADDR_W-1:0] x_addr,
   output logic [DATA_W-1:0] x_wdata,
   input  logic              x_ack,
   input  logic [DATA_W-1:0] x_rdata,
   input  logic [ADDR_W-1:0] cfg_win_lo,
   input  logic [ADDR_W-1:0] cfg_win_hi,
   input  logic [ADDR_W-1:0] cfg_bar_addr,
   output logic [CNT_W-1:0]  bar_count
);

   initial begin : p_param_chk
      assert (ADDR_W >= 2)      else $fatal(1, "ADDR_W must be at least 2");
      assert (DATA_W >= 1)      else $fatal(1, "DATA_W must be at least 1");
      assert (CNT_W >= 1)       else $fatal(1, "CNT_W must be at least 1");
      assert (DEC_LO <= DEC_HI) else $fatal(1, "decoded region is empty");
   end

   logic              m_hit;
   logic [ADDR_W-1:0] bar_addr;
   logic              bar_done;

   wbb_win_dec #(
      .AW           (ADDR_W),
      .HI_INCLUSIVE (HI_INCLUSIVE)
   ) u_win (
      .addr (m_addr),
      .lo   (cfg_win_lo),
      .hi   (cfg_win_hi),
      .hit  (m_hit)
   );

   wbb_bar_sel #(
      .AW           (ADDR_W),
      .HI_INCLUSIVE (HI_INCLUSIVE),
      .DEC_LO       (DEC_LO),
      .DEC_HI       (DEC_HI)
   ) u_bar_sel (
      .cfg_bar  (cfg_bar_addr),
      .win_lo   (cfg_win_lo),
      .win_hi   (cfg_win_hi),
      .bar_addr (bar_addr)
   );

   wbb_seq #(
      .AW (ADDR_W),
      .DW (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_req    (m_req),
      .m_we     (m_we),
      .m_addr   (m_addr),
      .m_wdata  (m_wdata),
      .m_hit    (m_hit),
      .m_ack    (m_ack),
      .m_rdata  (m_rdata),
      .bar_addr (bar_addr),
      .x_req    (x_req),
      .x_we     (x_we),
      .x_addr   (x_addr),
      .x_wdata  (x_wdata),
      .x_ack    (x_ack),
      .x_rdata  (x_rdata),
      .bar_done (bar_done)
   );

   wbb_bar_cnt #(
      .CW       (CNT_W),
      .SATURATE (CNT_SATURATE)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (bar_done),
      .count (bar_count)
   );

endmodule

// File: rtl/wbb_bridge_chk.sv
module wbb_bridge_chk #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16,
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          m_we,
   input  logic          m_ack,
   input  logic [DW-1:0] m_rdata,
   input  logic          x_req,
   input  logic          x_we,
   input  logic [AW-1:0] x_addr,
   input  logic [DW-1:0] x_wdata,
   input  logic          x_ack,
   input  logic [AW-1:0] cfg_win_lo,
   input  logic [AW-1:0] cfg_win_hi,
   input  logic [CW-1:0] bar_count
);

   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic x_in_win;
   assign x_in_win = (x_addr >= cfg_win_lo) && (x_addr <= cfg_win_hi);

   // R8
   x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_req && !x_ack) |=> (x_req && $stable(x_addr) && $stable(x_we) && $stable(x_wdata)));

   // R2
   pass_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_req && x_ack && !(x_we && x_in_win)) |=> m_ack);

   // R3
   barrier_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_req && x_ack && x_we && x_in_win) |=> (x_req && !x_we && !m_ack));

   // R4
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_ack |=> !m_ack);

   // R5
   wr_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_ack && m_we) |-> (m_rdata == '0));

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((bar_count == $past(bar_count)) ||
                (bar_count == $past(bar_count) + ONE) ||
                (bar_count == '0)));

endmodule

bind wr_barrier_bridge wbb_bridge_chk #(
   .AW (ADDR_W),
   .DW (DATA_W),
   .CW (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m_we       (m_we),
   .m_ack      (m_ack),
   .m_rdata    (m_rdata),
   .x_req      (x_req),
   .x_we       (x_we),
   .x_addr     (x_addr),
   .x_wdata    (x_wdata),
   .x_ack      (x_ack),
   .cfg_win_lo (cfg_win_lo),
   .cfg_win_hi (cfg_win_hi),
   .bar_count  (bar_count)
);

// File: tb/tb_wr_barrier_bridge.sv
`timescale 1ns/1ps
module tb_wr_barrier_bridge;

   localparam int unsigned AW = 16;
   localparam int unsigned DW = 16;
   localparam int unsigned CW = 4;
   localparam logic [15:0] DLO   = 16'h8000;
   localparam logic [15:0] DHI   = 16'hBFFF;
   localparam logic [15:0] WLO   = 16'h1000;
   localparam logic [15:0] WHI   = 16'h10FF;
   localparam logic [15:0] BAR0  = 16'h8040;
   localparam logic [15:0] SCRAM = 16'h5A5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          m_req = 1'b0;
   logic          m_we = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wdata = '0;
   logic          m_ack;
   logic [DW-1:0] m_rdata;
   logic          x_req;
   logic          x_we;
   logic [AW-1:0] x_addr;
   logic [DW-1:0] x_wdata;
   logic          x_ack = 1'b0;
   logic [DW-1:0] x_rdata = '0;
   logic [AW-1:0] cfg_win_lo = WLO;
   logic [AW-1:0] cfg_win_hi = WHI;
   logic [AW-1:0] cfg_bar_addr = BAR0;
   logic [CW-1:0] bar_count;

   always #5 clk = ~clk;

   wr_barrier_bridge #(
      .ADDR_W (AW),
      .DATA_W (DW),
      .CNT_W  (CW),
      .DEC_LO (DLO),
      .DEC_HI (DHI)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .m_req        (m_req),
      .m_we         (m_we),
      .m_addr       (m_addr),
      .m_wdata      (m_wdata),
      .m_ack        (m_ack),
      .m_rdata      (m_rdata),
      .x_req        (x_req),
      .x_we         (x_we),
      .x_addr       (x_addr),
      .x_wdata      (x_wdata),
      .x_ack        (x_ack),
      .x_rdata      (x_rdata),
      .cfg_win_lo   (cfg_win_lo),
      .cfg_win_hi   (cfg_win_hi),
      .cfg_bar_addr (cfg_bar_addr),
      .bar_count    (bar_count)
   );

   // ---------------- memory responder with transaction log ----------------
   int            lat_cfg = 0;
   int            wait_cnt = 0;
   int            log_n = 0;
   logic [AW-1:0] log_addr [64];
   logic          log_we   [64];
   logic [DW-1:0] log_wd   [64];

   always @(posedge clk) begin
      if (!rst_n) begin
         x_ack    <= 1'b0;
         wait_cnt <= 0;
      end else if (x_ack) begin
         x_ack    <= 1'b0;
         wait_cnt <= 0;
      end else if (x_req) begin
         if (wait_cnt >= lat_cfg) begin
            x_ack               <= 1'b1;
            x_rdata             <= x_addr ^ SCRAM;
            log_addr[log_n % 64] <= x_addr;
            log_we[log_n % 64]   <= x_we;
            log_wd[log_n % 64]   <= x_wdata;
            log_n               <= log_n + 1;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // ---------------- hold monitor for R8 ----------------
   int            hold_bad = 0;
   logic          pv_pend = 1'b0;
   logic [AW-1:0] pv_addr = '0;
   logic          pv_we = 1'b0;
   logic [DW-1:0] pv_wd = '0;

   always @(negedge clk) begin
      if (rst_n && pv_pend) begin
         if (!x_req || x_addr != pv_addr || x_we != pv_we || x_wdata != pv_wd)
            hold_bad <= hold_bad + 1;
      end
      pv_pend <= rst_n && x_req && !x_ack;
      pv_addr <= x_addr;
      pv_we   <= x_we;
      pv_wd   <= x_wdata;
   end

   // ---------------- scoreboard ----------------
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_access(input logic [15:0] a, input logic w, input logic [15:0] d,
                            output logic [15:0] rd);
      int guard;
      @(negedge clk);
      m_req = 1'b1; m_we = w; m_addr = a; m_wdata = d;
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!m_ack && guard < 200);
      rd = m_rdata;
      m_req = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0;
      // R4: acknowledge is a single-cycle pulse
      @(negedge clk);
      check(!m_ack, "R4", "ack width", {31'd0, m_ack}, 32'd0);
   endtask

   task automatic run_one(input logic [15:0] a, input logic w, input logic [15:0] d,
                          input logic bar, input logic [15:0] baddr);
      int n0;
      int nx;
      logic [15:0] rd;
      n0 = log_n;
      do_access(a, w, d, rd);
      nx = log_n - n0;
      if (bar) begin
         // R3 / R4: two transactions finished before the ack
         check(nx == 2, "R4", "ext count at ack", nx, 2);
         check(log_addr[(n0+1)%64] == baddr, "R3", "barrier addr",
               {16'd0, log_addr[(n0+1)%64]}, {16'd0, baddr});
         check(log_we[(n0+1)%64] == 1'b0, "R3", "barrier is read",
               {31'd0, log_we[(n0+1)%64]}, 32'd0);
      end else begin
         check(nx == 1, "R2", "ext count", nx, 1);
      end
      check(log_addr[n0%64] == a && log_we[n0%64] == w && (!w || log_wd[n0%64] == d),
            bar ? "R3" : "R2", "forwarded access",
            {log_addr[n0%64], log_wd[n0%64]}, {a, d});
      check(rd == (w ? 16'h0000 : (a ^ SCRAM)), w ? "R5" : "R2", "read data",
            {16'd0, rd}, {16'd0, (w ? 16'h0000 : (a ^ SCRAM))});
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic [15:0] addr;
      logic        we;
      logic [15:0] wdata;
      logic        bar;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VT [NV] = '{
      '{16'h0200, 1'b0, 16'h0000, 1'b0},   // read outside
      '{16'h3000, 1'b1, 16'hA1A1, 1'b0},   // write outside
      '{16'h1010, 1'b0, 16'h0000, 1'b0},   // read inside window
      '{16'h1000, 1'b1, 16'hB2B2, 1'b1},   // write at low bound
      '{16'h10FF, 1'b1, 16'hC3C3, 1'b1},   // write at high bound
      '{16'h1100, 1'b1, 16'hD4D4, 1'b0},   // one above high bound
      '{16'h0FFF, 1'b1, 16'hE5E5, 1'b0},   // one below low bound
      '{16'h1080, 1'b1, 16'hF6F6, 1'b1}    // write mid window
   };

   task automatic finish_run();
      check(hold_bad == 0, "R8", "external hold violations", hold_bad, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!m_ack && !x_req, "R1", "ack/req in reset", {30'd0, m_ack, x_req}, 32'd0);
      check(bar_count == '0, "R1", "count in reset", {28'd0, bar_count}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!m_ack && !x_req && bar_count == '0, "R1", "state after release",
            {26'd0, bar_count, m_ack, x_req}, 32'd0);

      // table walk with varying memory latency
      for (int i = 0; i < NV; i++) begin
         lat_cfg = i % 4;
         run_one(VT[i].addr, VT[i].we, VT[i].wdata, VT[i].bar, BAR0);
      end
      check(bar_count == 4'd3, "R7", "count after table", {28'd0, bar_count}, 3);

      // R6: barrier address selection
      lat_cfg = 1;
      @(negedge clk); cfg_bar_addr = 16'h1020;   // inside window and undecoded
      run_one(16'h1004, 1'b1, 16'h1111, 1'b1, DLO);
      @(negedge clk); cfg_bar_addr = 16'h7FFF;   // just below decoded region
      run_one(16'h1005, 1'b1, 16'h2222, 1'b1, DLO);
      @(negedge clk); cfg_bar_addr = 16'hBFFF;   // top of decoded region
      run_one(16'h1006, 1'b1, 16'h3333, 1'b1, 16'hBFFF);
      check(bar_count == 4'd6, "R7", "count after R6 group", {28'd0, bar_count}, 6);

      // R7: saturation at all-ones
      @(negedge clk); cfg_bar_addr = BAR0;
      lat_cfg = 0;
      for (int k = 0; k < 10; k++) begin
         run_one(16'h1040 + 16'(k), 1'b1, 16'h4000 + 16'(k), 1'b1, BAR0);
      end
      check(bar_count == 4'hF, "R7", "saturated count", {28'd0, bar_count}, 15);
      run_one(16'h10AA, 1'b1, 16'h5555, 1'b1, BAR0);
      check(bar_count == 4'hF, "R7", "count held at max", {28'd0, bar_count}, 15);

      // R2: read inside window after saturation still passes alone
      run_one(16'h10AA, 1'b0, 16'h0000, 1'b0, BAR0);

      done = 1'b1;
      finish_run();
   end

endmodule